// File: doc/BRIEF.md
# Two-Bus Register Bank

A bank of general-purpose registers placed between two shared data buses, A and B. On every cycle the controller picks, independently for each bus, one register to put on that bus. It also picks, independently for each bus, one register to capture that bus's value at the next rising clock edge. Reads are combinational. Writes are edge-triggered. A register can therefore place its current contents on a bus and be overwritten in the same cycle, and two registers can exchange values in one cycle through the two buses.

The tristate buses are modelled as multiplexers, each with a valid bit. When no register drives a bus, the bus carries the external value presented for it, and that value can be loaded like any other. The bank does not arbitrate loads. Keeping the two load targets apart is the controller's job. If both loads name the same register, the result is fixed, but it counts as undefined usage.

Top module: `dual_bus_regbank`

## Requirements
- R1: Asserting rst_ni low clears every register to zero asynchronously; after release each register reads zero on either bus.
- R2: While a drive enable is high, that bus output equals the register whose binary index is on the matching select, in the same cycle, and its valid bit is 1.
- R3: While a drive enable is low, that bus output equals the external input for that bus and its valid bit is 0.
- R4: One register may drive bus A and bus B in the same cycle, and both buses then show its value.
- R5: A load enable high with a select index makes that register take the current value of the named bus at the rising clock edge.
- R6: A load from bus A and a load from bus B into two different registers both take effect at the same edge.
- R7: When both loads name the same register, that register takes the bus B value.
- R8: A register that drives a bus and loads in the same cycle shows its old value on the bus until the edge; two registers can swap contents in one cycle through the two buses.
- R9: A register that no enabled load selects keeps its value.
- R10: A load select is ignored while its load enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; loads occur on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| drv_a_en_i | input | 1 | A register drives bus A |
| drv_a_sel_i | input | SEL_W | Index of the register driving bus A |
| drv_b_en_i | input | 1 | A register drives bus B |
| drv_b_sel_i | input | SEL_W | Index of the register driving bus B |
| ld_a_en_i | input | 1 | Load a register from bus A |
| ld_a_sel_i | input | SEL_W | Index of the register loaded from bus A |
| ld_b_en_i | input | 1 | Load a register from bus B |
| ld_b_sel_i | input | SEL_W | Index of the register loaded from bus B |
| ext_a_i | input | WIDTH | Value on bus A when no register drives it |
| ext_b_i | input | WIDTH | Value on bus B when no register drives it |
| bus_a_o | output | WIDTH | Bus A value |
| bus_a_vld_o | output | 1 | Bus A is driven by a register |
| bus_b_o | output | WIDTH | Bus B value |
| bus_b_vld_o | output | 1 | Bus B is driven by a register |

## Verification
Three kinds of operation can fall in the same cycle. A register can be driven and loaded in one cycle. Two registers can trade values across both buses. Both loads can name one register. The vector table sets up each of these on a single cycle. The bus outputs are checked before the edge, and should show the old contents. Each register involved is then driven again on the next vector, and its new value is checked. The double-load case is checked against the bus B value as documented, and it is marked as undefined usage for a controller.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned DEF_REGS  = 8;
endpackage

// File: rtl/dbus_slot.sv
module dbus_slot #(
  parameter int unsigned WIDTH = dbus_pkg::DEF_WIDTH,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned IDX   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_a_en_i,
  input  logic [SEL_W-1:0] ld_a_sel_i,
  input  logic             ld_b_en_i,
  input  logic [SEL_W-1:0] ld_b_sel_i,
  input  logic [WIDTH-1:0] bus_a_i,
  input  logic [WIDTH-1:0] bus_b_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

  logic hit_a, hit_b;
  assign hit_a = ld_a_en_i && (ld_a_sel_i == MY_SEL);
  assign hit_b = ld_b_en_i && (ld_b_sel_i == MY_SEL);

  // bus B takes precedence on a doubled load (undefined usage for the controller)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (hit_b) q_o <= bus_b_i;
    else if (hit_a) q_o <= bus_a_i;
  end

  assert_load_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(hit_a) && !$past(hit_b) |-> q_o == $past(bus_a_i));

  assert_b_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(hit_b) |-> q_o == $past(bus_b_i));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(hit_a) && !$past(hit_b) |-> $stable(q_o));
endmodule

// File: rtl/dbus_mux.sv
module dbus_mux #(
  parameter int unsigned WIDTH = dbus_pkg::DEF_WIDTH,
  parameter int unsigned NREGS = dbus_pkg::DEF_REGS,
  parameter int unsigned SEL_W = 3
) (
  input  logic [NREGS-1:0][WIDTH-1:0] regs_i,
  input  logic                        en_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [WIDTH-1:0]            ext_i,
  output logic [WIDTH-1:0]            bus_o,
  output logic                        vld_o
);
  logic [WIDTH-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (sel_i == SEL_W'(i)) pick = regs_i[i];
    end
  end

  assign bus_o = en_i ? pick : ext_i;
  assign vld_o = en_i;
endmodule

// File: rtl/dual_bus_regbank.sv
module dual_bus_regbank #(
  parameter int unsigned WIDTH = dbus_pkg::DEF_WIDTH,
  parameter int unsigned NREGS = dbus_pkg::DEF_REGS,
  localparam int unsigned SEL_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drv_a_en_i,
  input  logic [SEL_W-1:0] drv_a_sel_i,
  input  logic             drv_b_en_i,
  input  logic [SEL_W-1:0] drv_b_sel_i,
  input  logic             ld_a_en_i,
  input  logic [SEL_W-1:0] ld_a_sel_i,
  input  logic             ld_b_en_i,
  input  logic [SEL_W-1:0] ld_b_sel_i,
  input  logic [WIDTH-1:0] ext_a_i,
  input  logic [WIDTH-1:0] ext_b_i,
  output logic [WIDTH-1:0] bus_a_o,
  output logic             bus_a_vld_o,
  output logic [WIDTH-1:0] bus_b_o,
  output logic             bus_b_vld_o
);
  logic [NREGS-1:0][WIDTH-1:0] regs;

  for (genvar g = 0; g < NREGS; g++) begin : g_slot
    dbus_slot #(.WIDTH(WIDTH), .SEL_W(SEL_W), .IDX(g)) slot_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ld_a_en_i  (ld_a_en_i),
      .ld_a_sel_i (ld_a_sel_i),
      .ld_b_en_i  (ld_b_en_i),
      .ld_b_sel_i (ld_b_sel_i),
      .bus_a_i    (bus_a_o),
      .bus_b_i    (bus_b_o),
      .q_o        (regs[g])
    );
  end

  dbus_mux #(.WIDTH(WIDTH), .NREGS(NREGS), .SEL_W(SEL_W)) mux_a_i (
    .regs_i (regs),
    .en_i   (drv_a_en_i),
    .sel_i  (drv_a_sel_i),
    .ext_i  (ext_a_i),
    .bus_o  (bus_a_o),
    .vld_o  (bus_a_vld_o)
  );

  dbus_mux #(.WIDTH(WIDTH), .NREGS(NREGS), .SEL_W(SEL_W)) mux_b_i (
    .regs_i (regs),
    .en_i   (drv_b_en_i),
    .sel_i  (drv_b_sel_i),
    .ext_i  (ext_b_i),
    .bus_o  (bus_b_o),
    .vld_o  (bus_b_vld_o)
  );

  assert_bus_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_a_en_i && (32'(drv_a_sel_i) < NREGS) |-> bus_a_o == regs[drv_a_sel_i] && bus_a_vld_o);

  assert_bus_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_b_en_i && (32'(drv_b_sel_i) < NREGS) |-> bus_b_o == regs[drv_b_sel_i] && bus_b_vld_o);

  assert_pass_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_a_en_i |-> bus_a_o == ext_a_i && !bus_a_vld_o);

  assert_pass_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_b_en_i |-> bus_b_o == ext_b_i && !bus_b_vld_o);

  // the value driven before the edge must be the pre-edge contents
  assert_old_on_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(drv_a_en_i) && (32'($past(drv_a_sel_i)) < NREGS)
      && !$past(ld_a_en_i && ld_a_sel_i == drv_a_sel_i)
      && !$past(ld_b_en_i && ld_b_sel_i == drv_a_sel_i)
      |-> regs[$past(drv_a_sel_i)] == $past(bus_a_o));
endmodule

// File: tb/dual_bus_regbank_tb_top.sv
module dual_bus_regbank_tb_top;
  localparam int W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic drv_a_en_i = 0, drv_b_en_i = 0, ld_a_en_i = 0, ld_b_en_i = 0;
  logic [2:0] drv_a_sel_i = 0, drv_b_sel_i = 0, ld_a_sel_i = 0, ld_b_sel_i = 0;
  logic [W-1:0] ext_a_i = 0, ext_b_i = 0;
  logic [W-1:0] bus_a_o, bus_b_o;
  logic bus_a_vld_o, bus_b_vld_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  dual_bus_regbank #(.WIDTH(W), .NREGS(8)) dut_i (.*);

  typedef struct packed {
    logic da_en; logic [2:0] da_sel;
    logic db_en; logic [2:0] db_sel;
    logic la_en; logic [2:0] la_sel;
    logic lb_en; logic [2:0] lb_sel;
    logic [W-1:0] ext_a; logic [W-1:0] ext_b;
    logic [W-1:0] exp_a; logic [W-1:0] exp_b;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R3 + R5: external value on bus A loaded into r1
    '{1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd1, 1'b0,3'd0, 16'h1111,16'h0000, 16'h1111,16'h0000, 4'd5},
    // R6: r2 from A, r3 from B at one edge
    '{1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd2, 1'b1,3'd3, 16'h2222,16'h3333, 16'h2222,16'h3333, 4'd6},
    // R2: r1 on A, r2 on B
    '{1'b1,3'd1, 1'b1,3'd2, 1'b0,3'd0, 1'b0,3'd0, 16'h0bad,16'h0bad, 16'h1111,16'h2222, 4'd2},
    // R4: r3 on both buses
    '{1'b1,3'd3, 1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0, 16'h0bad,16'h0bad, 16'h3333,16'h3333, 4'd4},
    // R8: swap r1/r2, old values on buses
    '{1'b1,3'd1, 1'b1,3'd2, 1'b1,3'd2, 1'b1,3'd1, 16'h0bad,16'h0bad, 16'h1111,16'h2222, 4'd8},
    // R8: swapped contents visible
    '{1'b1,3'd1, 1'b1,3'd2, 1'b0,3'd0, 1'b0,3'd0, 16'h0bad,16'h0bad, 16'h2222,16'h1111, 4'd8},
    // R10: selects on r3 with enables low
    '{1'b0,3'd0, 1'b0,3'd0, 1'b0,3'd3, 1'b0,3'd3, 16'hdead,16'hbeef, 16'hdead,16'hbeef, 4'd10},
    // R10 + R9: r3 unchanged, r4 still reset value
    '{1'b1,3'd3, 1'b1,3'd4, 1'b0,3'd0, 1'b0,3'd0, 16'h0bad,16'h0bad, 16'h3333,16'h0000, 4'd10},
    // R7: both loads on r5 (undefined usage; B wins)
    '{1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd5, 1'b1,3'd5, 16'haaaa,16'hbbbb, 16'haaaa,16'hbbbb, 4'd7},
    // R7: r5 holds B value; R9: r1 untouched
    '{1'b1,3'd5, 1'b1,3'd1, 1'b0,3'd0, 1'b0,3'd0, 16'h0bad,16'h0bad, 16'hbbbb,16'h2222, 4'd7},
    // R5: top index r7 loaded from A while r0 drives B
    '{1'b0,3'd0, 1'b1,3'd0, 1'b1,3'd7, 1'b0,3'd0, 16'hffff,16'h0bad, 16'hffff,16'h0000, 4'd5},
    // R9: r7 and r6 read back
    '{1'b1,3'd7, 1'b1,3'd6, 1'b0,3'd0, 1'b0,3'd0, 16'h0bad,16'h0bad, 16'hffff,16'h0000, 4'd9}
  };

  task automatic check(input int req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic idle();
    drv_a_en_i = 0; drv_b_en_i = 0; ld_a_en_i = 0; ld_b_en_i = 0;
  endtask

  task automatic read_pair(input logic [2:0] a, input logic [2:0] b);
    drv_a_en_i = 1; drv_a_sel_i = a; drv_b_en_i = 1; drv_b_sel_i = b;
    ld_a_en_i = 0; ld_b_en_i = 0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    // R1: every register reads zero after reset
    for (int r = 0; r < 8; r++) begin
      @(negedge clk_i);
      read_pair(3'(r), 3'(7 - r));
      #2;
      check(1, bus_a_o, '0);
      check(1, bus_b_o, '0);
    end

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      drv_a_en_i = VECS[v].da_en; drv_a_sel_i = VECS[v].da_sel;
      drv_b_en_i = VECS[v].db_en; drv_b_sel_i = VECS[v].db_sel;
      ld_a_en_i  = VECS[v].la_en; ld_a_sel_i  = VECS[v].la_sel;
      ld_b_en_i  = VECS[v].lb_en; ld_b_sel_i  = VECS[v].lb_sel;
      ext_a_i    = VECS[v].ext_a; ext_b_i     = VECS[v].ext_b;
      #2;
      check(int'(VECS[v].req), bus_a_o, VECS[v].exp_a);
      check(int'(VECS[v].req), bus_b_o, VECS[v].exp_b);
      // R2/R3 valid bits follow the drive enables
      check(3, W'(bus_a_vld_o), W'(VECS[v].da_en));
      check(3, W'(bus_b_vld_o), W'(VECS[v].db_en));
    end

    // R8: same register drives A and loads from B; old value before edge, new after
    @(negedge clk_i);
    drv_a_en_i = 1; drv_a_sel_i = 3'd6; drv_b_en_i = 0; ext_b_i = 16'h6006;
    ld_a_en_i = 0; ld_b_en_i = 1; ld_b_sel_i = 3'd6;
    #2;
    check(8, bus_a_o, 16'h0000);
    @(negedge clk_i);
    read_pair(3'd6, 3'd6);
    #2;
    check(8, bus_a_o, 16'h6006);

    // R5: register-to-register move over bus A (r5 -> r0)
    @(negedge clk_i);
    drv_a_en_i = 1; drv_a_sel_i = 3'd5; drv_b_en_i = 0;
    ld_a_en_i = 1; ld_a_sel_i = 3'd0; ld_b_en_i = 0;
    @(negedge clk_i);
    read_pair(3'd0, 3'd5);
    #2;
    check(5, bus_a_o, 16'hbbbb);
    check(9, bus_b_o, 16'hbbbb);

    // R1: asynchronous reset mid-run clears loaded registers
    @(negedge clk_i);
    idle();
    #3 rst_ni = 0;
    #2;
    read_pair(3'd7, 3'd1);
    #1;
    check(1, bus_a_o, '0);
    check(1, bus_b_o, '0);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    read_pair(3'd5, 3'd0);
    #2;
    check(1, bus_a_o, '0);
    check(1, bus_b_o, '0);

    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule